// File: doc/BRIEF.md
# Free-Running Time-Base Counter Block

This block gives software a set of time references that need no setup. Two up counters advance at fixed rates of one step per second and one hundred steps per second. Both rates come from dividers whose lengths are derived from the `CLK_HZ` parameter. A third up counter, the event counter, steps whenever a 32-bit down-counter reaches zero. That down-counter then refills itself from a software-programmed reload value, so the event counter rate is the clock rate divided by (reload + 1). The block also reports two push-button inputs after resynchronising them to the clock.

All counters start from zero when reset is released and then run without further control. Software can preset any counter to a new value at any time. Access is through a zero-wait APB-style register port. Read data is driven combinationally from the address while `psel` is high. A write commits on the clock edge at which `psel`, `penable` and `pwrite` are all high. The bus has no ready signal and never applies back-pressure, so every transfer completes in its access cycle. No data stream passes through the block, so it has no valid/ready interface.

Top module: `sysio_timebase`

## Requirements
- R1: After reset every readable register returns zero, and the prescale reload value and running count are both zero. A zero running count means the event counter steps on every clock edge from the first edge after reset.
- R2: Byte offset 0x008 returns the two button inputs in bits 1:0 and zero in bits 31:2. Each button passes through two flip-flops, so a change on `btn_i` is visible after exactly two clock edges. Writes to 0x008 change nothing.
- R3: The seconds counter at byte offset 0x010 increments once every `CLK_HZ` clock edges. The first increment comes at edge `CLK_HZ` after reset.
- R4: The centisecond counter at byte offset 0x014 increments once every `CLK_HZ/100` clock edges. The first increment comes at edge `CLK_HZ/100` after reset.
- R5: A write to byte offset 0x01C loads both the stored reload value and the running prescale count with the written data. A read of 0x01C returns the reload value.
- R6: On each clock edge, a non-zero running prescale count decreases by one, and a zero count is refilled from the reload value. The event counter at byte offset 0x018 increments on every edge at which the count, before that edge, is zero. With reload N this gives one step every N+1 edges.
- R7: A write to 0x010, 0x014 or 0x018 loads that counter with the written data. The written value takes precedence over an increment due on the same edge.
- R8: All three counters wrap from 0xFFFFFFFF to 0x00000000.
- R9: Every other byte address reads as zero, and writes to it change no register. This includes addresses that are not multiples of four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at `CLK_HZ` |
| rst_n | input | 1 | Active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while `psel` is high |
| btn_i | input | 2 | Asynchronous push-button levels |

## Verification
The button-latency assertion compares the synchronised value with `btn_i` from two edges earlier. It therefore relies on `btn_i` being held low during reset, and the bench keeps the buttons at zero until reset is released. The counter-step assertions treat a write strobe as the only event allowed to break the rate of one step per tick. The bench therefore changes counters only through complete APB transfers, whose inputs it drives on falling edges. The bench runs with `CLK_HZ` at 1000, which gives dividers of 1000 and 10 edges. It predicts each counter value by dividing the edge count since reset or since the last preset.

// File: rtl/tbase_pkg.sv
`timescale 1ns/1ps
package tbase_pkg;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned ADDR_W      = 12;
  localparam int unsigned BTN_W       = 2;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned NUM_CTR     = 3;

  localparam logic [ADDR_W-1:0] OFS_BTN  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_SEC  = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_HUND = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_CYC  = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_PRE  = 12'h01C;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_BTN, SEL_SEC, SEL_HUND, SEL_CYC, SEL_PRE
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_BTN:  return SEL_BTN;
      OFS_SEC:  return SEL_SEC;
      OFS_HUND: return SEL_HUND;
      OFS_CYC:  return SEL_CYC;
      OFS_PRE:  return SEL_PRE;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/tb_tickdiv.sv
`timescale 1ns/1ps
module tb_tickdiv #(
  parameter int unsigned DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  if (DIV <= 1) begin : g_pass
    assign tick_o = 1'b1;
  end else begin : g_cnt
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt <= '0;
      else if (cnt == CW'(DIV - 1))   cnt <= '0;
      else                            cnt <= cnt + 1'b1;
    end
    assign tick_o = (cnt == CW'(DIV - 1));
  end
endmodule

// File: rtl/tb_upcount.sv
`timescale 1ns/1ps
module tb_upcount #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_o <= '0;
    else if (load_i) count_o <= load_val_i;
    else if (inc_i)  count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/tb_prescale.sv
`timescale 1ns/1ps
module tb_prescale #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o,
  output logic [W-1:0] count_o,
  output logic [W-1:0] reload_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o  <= '0;
      reload_o <= '0;
    end else if (load_i) begin
      count_o  <= load_val_i;
      reload_o <= load_val_i;
    end else if (count_o == '0) begin
      count_o  <= reload_o;
    end else begin
      count_o  <= count_o - 1'b1;
    end
  end
  assign zero_o = (count_o == '0);
endmodule

// File: rtl/tb_btnsync.sv
`timescale 1ns/1ps
module tb_btnsync #(
  parameter int unsigned N      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else if (s == 0) chain[s] <= d_i;
      else chain[s] <= chain[(s == 0) ? 0 : s - 1];
    end
  end
  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/sysio_timebase.sv
`timescale 1ns/1ps
module sysio_timebase
  import tbase_pkg::*;
#(
  parameter int unsigned CLK_HZ = 32_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [BTN_W-1:0]  btn_i
);
  localparam int unsigned DIV_SEC  = CLK_HZ;
  localparam int unsigned DIV_HUND = CLK_HZ / 100;

  reg_sel_e           sel;
  logic               wr_en;
  logic               wr_sec, wr_hund, wr_cyc, wr_pre;
  logic               tick_sec, tick_hund, pre_zero;
  logic [BTN_W-1:0]   btn_s;
  logic [DATA_W-1:0]  pre_cnt, pre_rel;
  logic [DATA_W-1:0]  sec_q, hund_q, cyc_q;
  logic [NUM_CTR-1:0] ctr_load, ctr_tick;
  logic [DATA_W-1:0]  ctr_q [NUM_CTR];

  assign sel     = decode(paddr);
  assign wr_en   = psel & penable & pwrite;
  assign wr_sec  = wr_en && (sel == SEL_SEC);
  assign wr_hund = wr_en && (sel == SEL_HUND);
  assign wr_cyc  = wr_en && (sel == SEL_CYC);
  assign wr_pre  = wr_en && (sel == SEL_PRE);

  tb_tickdiv #(.DIV(DIV_SEC)) u_div_sec (
    .clk(clk), .rst_n(rst_n), .tick_o(tick_sec)
  );

  tb_tickdiv #(.DIV(DIV_HUND)) u_div_hund (
    .clk(clk), .rst_n(rst_n), .tick_o(tick_hund)
  );

  tb_prescale #(.W(DATA_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .load_i(wr_pre), .load_val_i(pwdata),
    .zero_o(pre_zero), .count_o(pre_cnt), .reload_o(pre_rel)
  );

  tb_btnsync #(.N(BTN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(btn_i), .q_o(btn_s)
  );

  assign ctr_load = {wr_cyc, wr_hund, wr_sec};
  assign ctr_tick = {pre_zero, tick_hund, tick_sec};

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    tb_upcount #(.W(DATA_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .load_i(ctr_load[g]), .load_val_i(pwdata),
      .inc_i(ctr_tick[g]), .count_o(ctr_q[g])
    );
  end

  assign sec_q  = ctr_q[0];
  assign hund_q = ctr_q[1];
  assign cyc_q  = ctr_q[2];

  always_comb begin
    case (sel)
      SEL_BTN:  prdata = {{(DATA_W-BTN_W){1'b0}}, btn_s};
      SEL_SEC:  prdata = sec_q;
      SEL_HUND: prdata = hund_q;
      SEL_CYC:  prdata = cyc_q;
      SEL_PRE:  prdata = pre_rel;
      default:  prdata = '0;
    endcase
  end
endmodule

// File: rtl/sysio_timebase_chk.sv
`timescale 1ns/1ps
module sysio_timebase_chk
  import tbase_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic [DATA_W-1:0] prdata,
  input logic [BTN_W-1:0]  btn_i,
  input logic [BTN_W-1:0]  btn_s,
  input logic              wr_sec,
  input logic              wr_hund,
  input logic              wr_cyc,
  input logic              wr_pre,
  input logic [DATA_W-1:0] sec_q,
  input logic [DATA_W-1:0] hund_q,
  input logic [DATA_W-1:0] cyc_q,
  input logic [DATA_W-1:0] pre_cnt,
  input logic [DATA_W-1:0] pre_rel
);
  // R2
  btn_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    btn_s == $past(btn_i, 2));

  // R2
  btn_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && paddr == OFS_BTN) |-> prdata[DATA_W-1:BTN_W] == '0);

  // R3
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sec |=> (sec_q == $past(sec_q) || sec_q == $past(sec_q) + 1'b1));

  // R4
  hund_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hund |=> (hund_q == $past(hund_q) || hund_q == $past(hund_q) + 1'b1));

  // R5
  pre_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pre |=> (pre_cnt == $past(pwdata) && pre_rel == $past(pwdata)));

  // R6
  pre_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_cnt == '0 && !wr_pre) |=> pre_cnt == $past(pre_rel));

  // R6
  pre_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_cnt != '0 && !wr_pre) |=> pre_cnt == $past(pre_cnt) - 1'b1);

  // R6
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cyc |=> cyc_q == $past(cyc_q) + DATA_W'($past(pre_cnt) == '0));

  // R7
  preset_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sec |=> sec_q == $past(pwdata));

  // R7
  preset_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cyc |=> cyc_q == $past(pwdata));

  // R8
  cyc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == '1 && pre_cnt == '0 && !wr_cyc) |=> cyc_q == '0);
endmodule

bind sysio_timebase sysio_timebase_chk u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .paddr(paddr), .pwdata(pwdata),
  .prdata(prdata), .btn_i(btn_i), .btn_s(btn_s), .wr_sec(wr_sec),
  .wr_hund(wr_hund), .wr_cyc(wr_cyc), .wr_pre(wr_pre), .sec_q(sec_q),
  .hund_q(hund_q), .cyc_q(cyc_q), .pre_cnt(pre_cnt), .pre_rel(pre_rel)
);

// File: tb/sysio_timebase_bench.sv
`timescale 1ns/1ps
module sysio_timebase_bench;
  localparam int unsigned HZ   = 1000;
  localparam int unsigned DSEC = HZ;
  localparam int unsigned DHUN = HZ / 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [1:0]  btn = '0;

  int unsigned n = 0;
  int total = 0, fails = 0;
  bit done = 0;

  int unsigned sec_c = 0, hund_c = 0, cyc_c = 0, pre_w = 0, pre_n = 0;
  logic [31:0] sec_b = 0, hund_b = 0, cyc_b = 0;

  always #5 clk = ~clk;
  always @(posedge clk) if (rst_n) n <= n + 1;

  sysio_timebase #(.CLK_HZ(HZ)) u_sysio_timebase (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .btn_i(btn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, output int unsigned at);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); at = n; psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output int unsigned at);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    #1; d = prdata; at = n;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  function automatic logic [31:0] e_sec(input int unsigned at);
    return sec_b + 32'(at / DSEC - sec_c / DSEC);
  endfunction
  function automatic logic [31:0] e_hund(input int unsigned at);
    return hund_b + 32'(at / DHUN - hund_c / DHUN);
  endfunction
  function automatic logic [31:0] e_cyc(input int unsigned at);
    return cyc_b + 32'((at - pre_w) / (pre_n + 1) - (cyc_c - pre_w) / (pre_n + 1));
  endfunction

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int unsigned at, tmp;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state of every register
    rd(12'h010, v, at); chk("R1 sec", v, 32'd0);
    rd(12'h014, v, at); chk("R1 hund", v, e_hund(at));
    rd(12'h008, v, at); chk("R1 btn", v, 32'd0);
    rd(12'h01C, v, at); chk("R1 reload", v, 32'd0);
    rd(12'h018, v, at); chk("R1 cyc", v, 32'(at));

    // R2: two-edge synchroniser latency for every button pattern
    for (int b = 0; b < 4; b++) begin
      logic [1:0] old;
      old = btn;
      btn = 2'(b);
      @(negedge clk);
      rd(12'h008, v, at); chk("R2 after one edge", v, {30'd0, old});
      rd(12'h008, v, at); chk("R2 after two edges", v, 32'(b));
    end
    wr(12'h008, 32'h0000_0000, at);
    rd(12'h008, v, at); chk("R2 write ignored", v, 32'd3);
    btn = 0;

    // R3 R4: sweep sample phases across many divider periods
    for (int i = 0; i < 60; i++) begin
      repeat ((i * 7) % 23 + 1) @(negedge clk);
      rd(12'h014, v, at); chk("R4 hund rate", v, e_hund(at));
      rd(12'h010, v, at); chk("R3 sec rate", v, e_sec(at));
    end
    repeat (1200) @(negedge clk);
    rd(12'h010, v, at); chk("R3 sec rate long", v, e_sec(at));

    // R7: preset then immediate read
    wr(12'h014, 32'd1234, at); hund_b = 32'd1234; hund_c = at;
    rd(12'h014, v, at); chk("R7 hund preset", v, e_hund(at));

    // R8: seconds and centiseconds wrap
    wr(12'h010, 32'hFFFF_FFFF, at); sec_b = 32'hFFFF_FFFF; sec_c = at;
    repeat (DSEC + 5) @(negedge clk);
    rd(12'h010, v, at); chk("R8 sec wrap", v, e_sec(at));
    wr(12'h014, 32'hFFFF_FFFE, at); hund_b = 32'hFFFF_FFFE; hund_c = at;
    repeat (25) @(negedge clk);
    rd(12'h014, v, at); chk("R8 hund wrap", v, e_hund(at));

    // R5 R6: prescale sweep
    for (int p = 0; p < 10; p++) begin
      tmp = (p == 9) ? 100 : p;
      wr(12'h01C, 32'(tmp), at); pre_n = tmp; pre_w = at;
      rd(12'h01C, v, at); chk("R5 reload readback", v, 32'(tmp));
      wr(12'h018, 32'd0, at); cyc_b = 0; cyc_c = at;
      for (int k = 0; k < 4; k++) begin
        repeat (k * 3 + tmp) @(negedge clk);
        rd(12'h018, v, at); chk("R6 event count", v, e_cyc(at));
      end
    end

    // R7: write wins over a same-edge increment (reload 0 steps every edge)
    wr(12'h01C, 32'd0, at); pre_n = 0; pre_w = at;
    wr(12'h018, 32'h55, at); cyc_b = 32'h55; cyc_c = at;
    rd(12'h018, v, at); chk("R7 write beats tick", v, 32'h55);

    // R8: event counter wrap
    wr(12'h018, 32'hFFFF_FFFD, at); cyc_b = 32'hFFFF_FFFD; cyc_c = at;
    repeat (5) @(negedge clk);
    rd(12'h018, v, at); chk("R8 cyc wrap", v, e_cyc(at));

    // R9: unmapped and misaligned addresses
    rd(12'h000, v, at); chk("R9 read 0x000", v, 0);
    rd(12'h004, v, at); chk("R9 read 0x004", v, 0);
    rd(12'h00C, v, at); chk("R9 read 0x00C", v, 0);
    rd(12'h011, v, at); chk("R9 read 0x011", v, 0);
    rd(12'h020, v, at); chk("R9 read 0x020", v, 0);
    rd(12'hFFC, v, at); chk("R9 read 0xFFC", v, 0);
    wr(12'h00C, 32'hDEAD_BEEF, at);
    wr(12'h011, 32'h0000_0007, at);
    wr(12'h01D, 32'h0000_0009, at);
    rd(12'h00C, v, at); chk("R9 0x00C stays zero", v, 0);
    rd(12'h010, v, at); chk("R9 sec untouched", v, e_sec(at));
    rd(12'h01C, v, at); chk("R9 reload untouched", v, 32'd0);

    done = 1;
    summary();
    $finish;
  end
endmodule